// File: doc/BRIEF.md
# Integral Path Gain Calibration Controller

This block runs a one-time calibration of the integral-path gain in a dual-path PLL, once the chip is out of reset. It sets two codes for the analog loop. The first is a thermometer-coded enable for the integral charge-pump current slices. The second is a binary-weighted loop-capacitor setting. Both start at their maximum values.

For each measurement the controller first qualifies lock. Lock is declared when a phase-detector in-window flag has stayed high for a programmable number of consecutive reference cycles. The controller then asks an external measurement unit for an offset-cancelled crossover time. It compares the returned time against a target that is sampled when calibration starts.

The search runs in two stages. In the first stage, current slices are removed one at a time while the loop responds faster than the target. Once the response becomes slower than the target, the second stage begins. It removes capacitance one code step at a time until the response is back at or below the target. Running out of either code ends the run with an error flag raised together with done.

Top module: `igain_cal_ctrl`

## Requirements
- R1: Out of reset, all current slices are enabled, the capacitor code is at its maximum (all ones), and busy, done and error are low.
- R2: The slice enable is a thermometer code: when n slices are on, bits 0 to n-1 are high and all other bits are low.
- R3: A measurement request is issued only after the in-window flag has been high on at least lockLen consecutive clock edges. The count starts after the start edge or after the latest code change, and any low sample restarts it.
- R4: The measurement request is a single-cycle pulse, issued once per lock.
- R5: In the first stage, a returned time below the target removes exactly one current slice, after which lock is requalified and a new measurement is taken.
- R6: In the first stage, a time above the target lowers the capacitor code by one and moves the search to the second stage. A time equal to the target ends calibration with both codes unchanged.
- R7: In the second stage, a time above the target lowers the capacitor code by one and repeats the measurement. A time at or below the target ends calibration without error.
- R8: If the time is still below the target while only MIN_SLICES slices remain, calibration ends with done and error high and the codes held.
- R9: If the time is still above the target while the capacitor code is zero, calibration ends with done and error high.
- R10: Busy is high from the start edge until completion. Done then stays high, busy stays low, and the codes no longer change.
- R11: After completion, a further start pulse is ignored until the next reset: no request is issued and the codes and flags stay as they are.
- R12: Every code change is a single step down: one slice fewer, or the capacitor code minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rstN | input | 1 | Active-low reset |
| startCal | input | 1 | Start pulse (honoured once per reset) |
| inWindow | input | 1 | Phase-detector input is inside the lock window |
| lockLen | input | LOCK_W | Consecutive in-window cycles needed to declare lock |
| targetTime | input | TIME_W | Target crossover time, sampled at start |
| measValid | input | 1 | Measurement result is valid this cycle |
| measTime | input | TIME_W | Averaged crossover time |
| measReq | output | 1 | Request one crossover-time measurement |
| cpEnable | output | NSLICE | Thermometer enable of integral current slices |
| capCode | output | CAP_W | Binary loop-capacitor code |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished |
| calErr | output | 1 | A code saturated before the exit condition was met |

## Verification
The bench answers each request with a time that grows with capacitance and shrinks with current, in the way a real integral path behaves. Against this model it tries several targets. A mid-range target exercises both stages. A target equal to the first reading ends the run at once. A very large target drives the current to its floor, and a zero target drives the capacitor to zero, so each saturation path is separated from the normal exit. Some runs use a steady in-window flag and others a periodically broken one, which shows whether the lock count restarts on every excursion rather than just accumulating. A final start pulse after completion shows whether calibration is really limited to one run per reset.

// File: rtl/igcal_pkg.sv
package igcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_REQ,
    ST_MEAS,
    ST_DONE
  } igcState_t;

  typedef struct packed {
    logic clrLock;
    logic decCp;
    logic decCap;
    logic loadTarget;
  } igcStrobe_t;

endpackage

// File: rtl/igcal_datapath.sv
module igcal_datapath
  import igcal_pkg::*;
#(
  parameter int NSLICE     = 10,
  parameter int MIN_SLICES = 1,
  parameter int CAP_W      = 5,
  parameter int TIME_W     = 12,
  parameter int LOCK_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  igcStrobe_t        strobe,
  input  logic              inWindow,
  input  logic [LOCK_W-1:0] lockLen,
  input  logic [TIME_W-1:0] targetIn,
  input  logic [TIME_W-1:0] measTime,
  output logic              locked,
  output logic              measFast,
  output logic              measSlow,
  output logic              cpAtMin,
  output logic              capZero,
  output logic [NSLICE-1:0] cpEnable,
  output logic [CAP_W-1:0]  capCode
);

  localparam int CP_W = $clog2(NSLICE + 1);
  localparam logic [CP_W-1:0]  CP_MAX  = CP_W'(NSLICE);
  localparam logic [CP_W-1:0]  CP_MIN  = CP_W'(MIN_SLICES);
  localparam logic [CAP_W-1:0] CAP_MAX = '1;

  logic [CP_W-1:0]   cpCount;
  logic [CAP_W-1:0]  capReg;
  logic [TIME_W-1:0] targetReg;
  logic [LOCK_W-1:0] lockCnt;

  // code registers: start at maximum, only ever step down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpCount <= CP_MAX;
      capReg  <= CAP_MAX;
    end else begin
      if (strobe.decCp && cpCount != CP_MIN) cpCount <= cpCount - 1'b1;
      if (strobe.decCap && capReg != '0)     capReg  <= capReg - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  targetReg <= '0;
    else if (strobe.loadTarget) targetReg <= targetIn;
  end

  // lock qualifier: consecutive in-window cycles, saturating at lockLen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lockCnt <= '0;
    else if (strobe.clrLock)  lockCnt <= '0;
    else if (!inWindow)       lockCnt <= '0;
    else if (lockCnt != lockLen) lockCnt <= lockCnt + 1'b1;
  end

  assign locked   = (lockCnt == lockLen);
  assign measFast = (measTime < targetReg);
  assign measSlow = (measTime > targetReg);
  assign cpAtMin  = (cpCount == CP_MIN);
  assign capZero  = (capReg == '0);
  assign capCode  = capReg;

  for (genvar g = 0; g < NSLICE; g++) begin : g_therm
    assign cpEnable[g] = (cpCount > CP_W'(g));
  end

endmodule

// File: rtl/igcal_ctrl.sv
module igcal_ctrl
  import igcal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCal,
  input  logic       locked,
  input  logic       measValid,
  input  logic       measFast,
  input  logic       measSlow,
  input  logic       cpAtMin,
  input  logic       capZero,
  output igcStrobe_t strobe,
  output logic       measReq,
  output logic       busy,
  output logic       done,
  output logic       calErr
);

  igcState_t state, nxtState;
  logic      capStage, nxtCapStage;
  logic      errReg, nxtErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      capStage <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      state    <= nxtState;
      capStage <= nxtCapStage;
      errReg   <= nxtErr;
    end
  end

  always_comb begin
    nxtState    = state;
    nxtCapStage = capStage;
    nxtErr      = errReg;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.clrLock = 1'b1;
        if (startCal) begin
          strobe.loadTarget = 1'b1;
          nxtState = ST_LOCK;
        end
      end
      ST_LOCK: if (locked) nxtState = ST_REQ;
      ST_REQ:  nxtState = ST_MEAS;
      ST_MEAS: begin
        if (measValid) begin
          if (!capStage) begin
            if (measFast) begin
              if (cpAtMin) begin
                nxtErr   = 1'b1;
                nxtState = ST_DONE;
              end else begin
                strobe.decCp   = 1'b1;
                strobe.clrLock = 1'b1;
                nxtState = ST_LOCK;
              end
            end else if (measSlow) begin
              if (capZero) begin
                nxtErr   = 1'b1;
                nxtState = ST_DONE;
              end else begin
                strobe.decCap  = 1'b1;
                strobe.clrLock = 1'b1;
                nxtCapStage    = 1'b1;
                nxtState = ST_LOCK;
              end
            end else begin
              nxtState = ST_DONE;
            end
          end else begin
            if (measSlow) begin
              if (capZero) begin
                nxtErr   = 1'b1;
                nxtState = ST_DONE;
              end else begin
                strobe.decCap  = 1'b1;
                strobe.clrLock = 1'b1;
                nxtState = ST_LOCK;
              end
            end else begin
              nxtState = ST_DONE;
            end
          end
        end
      end
      ST_DONE: strobe.clrLock = 1'b1;
      default: nxtState = ST_IDLE;
    endcase
  end

  assign measReq = (state == ST_REQ);
  assign busy    = (state == ST_LOCK) || (state == ST_REQ) || (state == ST_MEAS);
  assign done    = (state == ST_DONE);
  assign calErr  = errReg;

endmodule

// File: rtl/igain_cal_ctrl.sv
module igain_cal_ctrl
  import igcal_pkg::*;
#(
  parameter int NSLICE     = 10,
  parameter int MIN_SLICES = 1,
  parameter int CAP_W      = 5,
  parameter int TIME_W     = 12,
  parameter int LOCK_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCal,
  input  logic              inWindow,
  input  logic [LOCK_W-1:0] lockLen,
  input  logic [TIME_W-1:0] targetTime,
  input  logic              measValid,
  input  logic [TIME_W-1:0] measTime,
  output logic              measReq,
  output logic [NSLICE-1:0] cpEnable,
  output logic [CAP_W-1:0]  capCode,
  output logic              busy,
  output logic              done,
  output logic              calErr
);

  igcStrobe_t strobe;
  logic locked, measFast, measSlow, cpAtMin, capZero;

  igcal_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startCal  (startCal),
    .locked    (locked),
    .measValid (measValid),
    .measFast  (measFast),
    .measSlow  (measSlow),
    .cpAtMin   (cpAtMin),
    .capZero   (capZero),
    .strobe    (strobe),
    .measReq   (measReq),
    .busy      (busy),
    .done      (done),
    .calErr    (calErr)
  );

  igcal_datapath #(
    .NSLICE     (NSLICE),
    .MIN_SLICES (MIN_SLICES),
    .CAP_W      (CAP_W),
    .TIME_W     (TIME_W),
    .LOCK_W     (LOCK_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inWindow (inWindow),
    .lockLen  (lockLen),
    .targetIn (targetTime),
    .measTime (measTime),
    .locked   (locked),
    .measFast (measFast),
    .measSlow (measSlow),
    .cpAtMin  (cpAtMin),
    .capZero  (capZero),
    .cpEnable (cpEnable),
    .capCode  (capCode)
  );

endmodule

// File: rtl/igcal_checker.sv
module igcal_checker #(
  parameter int NSLICE = 10,
  parameter int CAP_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              measReq,
  input logic              busy,
  input logic              done,
  input logic              calErr,
  input logic [NSLICE-1:0] cpEnable,
  input logic [CAP_W-1:0]  capCode
);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    measReq |=> !measReq);

  // R2
  therm_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpEnable & (cpEnable + NSLICE'(1))) == '0);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    calErr |-> done);

  // R11
  codes_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(capCode) && $stable(cpEnable)));

  // R12
  cap_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capCode != $past(capCode)) |-> (capCode == $past(capCode) - CAP_W'(1)));

  // R12
  cp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpEnable != $past(cpEnable)) |-> ($countones(cpEnable) + 1 == $countones($past(cpEnable))));

endmodule

bind igain_cal_ctrl igcal_checker #(.NSLICE(NSLICE), .CAP_W(CAP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .measReq  (measReq),
  .busy     (busy),
  .done     (done),
  .calErr   (calErr),
  .cpEnable (cpEnable),
  .capCode  (capCode)
);

// File: tb/igain_cal_ctrl_test.sv
module igain_cal_ctrl_test;

  localparam int NSLICE = 10, MIN_SLICES = 1, CAP_W = 5, TIME_W = 12, LOCK_W = 16;

  logic clk = 1'b0, rstN = 1'b0, startCal = 1'b0, inWindow = 1'b1, measValid = 1'b0;
  logic [LOCK_W-1:0] lockLen = 16'd8;
  logic [TIME_W-1:0] targetTime = '0, measTime = '0;
  logic measReq, busy, done, calErr;
  logic [NSLICE-1:0] cpEnable;
  logic [CAP_W-1:0] capCode;

  always #5 clk = ~clk;

  igain_cal_ctrl #(.NSLICE(NSLICE), .MIN_SLICES(MIN_SLICES), .CAP_W(CAP_W),
    .TIME_W(TIME_W), .LOCK_W(LOCK_W)) uut (.*);

  typedef struct { int cp; int cap; int err; int nMeas; } expect_t;
  expect_t sbq[$];

  int total = 0, bad = 0, scaleTb = 10, reqCount = 0, cyc = 0, doneRuns = 0;
  bit glitchMode = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modelTime(int cp, int cap);
    return (scaleTb * (cap + 1)) / cp;
  endfunction

  function automatic expect_t predict(int target);
    expect_t e;
    int stage = 1;
    int t;
    e.cp = NSLICE; e.cap = (1 << CAP_W) - 1; e.err = 0; e.nMeas = 0;
    forever begin
      t = modelTime(e.cp, e.cap);
      e.nMeas++;
      if (stage == 1 && t < target) begin
        if (e.cp == MIN_SLICES) begin e.err = 1; break; end
        e.cp--;
      end else if (t > target) begin
        if (e.cap == 0) begin e.err = 1; break; end
        e.cap--; stage = 2;
      end else break;
    end
    return e;
  endfunction

  // in-window pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 inWindow = glitchMode ? ((cyc % 17) != 5) : 1'b1;
  end

  // measurement unit model
  initial begin
    forever begin
      @(negedge clk);
      if (measReq) begin
        int t;
        t = modelTime($countones(cpEnable), int'(capCode));
        repeat (3) @(posedge clk);
        #1 measValid = 1'b1; measTime = TIME_W'(t);
        @(posedge clk);
        #1 measValid = 1'b0;
      end
    end
  end

  // lock-run tracking (R3), pulse width (R4), step size (R12)
  int run = 0, runP1 = 0, runP2 = 0;
  logic startSeen = 0, reqPrev = 0;
  logic [NSLICE-1:0] cpPrev = '1;
  logic [CAP_W-1:0] capPrev = '1;
  always @(negedge clk) begin
    bit evt;
    evt = (cpEnable != cpPrev) || (capCode != capPrev) || startSeen;
    if (rstN && cpEnable != cpPrev)
      chk($countones(cpEnable) + 1 == $countones(cpPrev), "R12 slice step",
          $countones(cpEnable), $countones(cpPrev) - 1);
    if (rstN && capCode != capPrev)
      chk(capCode + 1 == capPrev, "R12 cap step", capCode, capPrev - 1);
    runP2 = runP1; runP1 = run;
    if (evt) run = inWindow ? 1 : 0;
    else     run = inWindow ? run + 1 : 0;
    if (measReq && !reqPrev) begin
      reqCount++;
      chk(runP2 >= int'(lockLen), "R3 lock run", runP2, lockLen);
    end
    if (measReq && reqPrev) chk(0, "R4 pulse width", 2, 1);
    reqPrev = measReq; startSeen = startCal;
    cpPrev = cpEnable; capPrev = capCode;
  end

  // scoreboard monitor
  logic doneSeen = 0;
  always @(negedge clk) begin
    if (!rstN) doneSeen = 0;
    else if (done && !doneSeen) begin
      expect_t e;
      doneSeen = 1;
      if (sbq.size() == 0) chk(0, "R10 unexpected done", 1, 0);
      else begin
        e = sbq.pop_front();
        chk(cpEnable == NSLICE'((1 << e.cp) - 1), "R2/R5 slices", cpEnable, (1 << e.cp) - 1);
        chk(int'(capCode) == e.cap, "R6/R7 cap code", capCode, e.cap);
        chk(int'(calErr) == e.err, "R8/R9 error flag", calErr, e.err);
        chk(reqCount == e.nMeas, "R5/R7 measurement count", reqCount, e.nMeas);
        chk(!busy, "R10 busy low at done", busy, 0);
      end
      doneRuns++;
    end
  end

  task automatic runCal(int target, int scale, int lk, bit glitch);
    int waitCyc = 0;
    rstN = 1'b0; glitchMode = glitch; scaleTb = scale;
    lockLen = LOCK_W'(lk); targetTime = TIME_W'(target);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(cpEnable == '1 && capCode == '1 && !busy && !done && !calErr, "R1 reset state",
        {cpEnable, capCode}, {NSLICE'('1), CAP_W'('1)});
    sbq.push_back(predict(target));
    reqCount = 0;
    @(posedge clk); #1 startCal = 1'b1;
    @(posedge clk); #1 startCal = 1'b0;
    @(negedge clk);
    chk(busy && !done, "R10 busy after start", busy, 1);
    while (!done && waitCyc < 30000) begin @(negedge clk); waitCyc++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    #(10 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    runCal(60, 10, 8, 0);     // both stages, normal exit (R5 R6 R7)
    runCal(32, 10, 8, 0);     // equal on first reading (R6)
    runCal(1000, 10, 6, 0);   // current floor (R8)
    runCal(0, 10, 4, 0);      // capacitor floor (R9)
    runCal(5, 10, 12, 1);     // broken window, stage two exit (R3 R7)
    runCal(100, 7, 10, 1);    // other scale with glitches
    begin : once_only
      logic [NSLICE-1:0] cpHold;
      logic [CAP_W-1:0] capHold;
      int reqBefore;
      cpHold = cpEnable; capHold = capCode; reqBefore = reqCount;
      @(posedge clk); #1 startCal = 1'b1;
      @(posedge clk); #1 startCal = 1'b0;
      repeat (100) @(negedge clk);
      // R11
      chk(reqCount == reqBefore, "R11 no request after done", reqCount, reqBefore);
      chk(done && !busy && cpEnable == cpHold && capCode == capHold, "R11 state held",
          {cpEnable, capCode}, {cpHold, capHold});
    end
    chk(doneRuns == 6, "R10 runs completed", doneRuns, 6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule